// File: doc/BRIEF.md
# Right Shifter with Carry

A purely combinational right-shift unit for a processor datapath. It takes a 32-bit operand and shifts it right by a variable distance, either arithmetically (vacated high bits take the operand's sign bit) or logically (vacated high bits become zero). The result appears on the same cycle as the inputs, with no registers on the path.

The unit also produces the next value of the carry flag. When the caller enables a carry update and the shift distance is non-zero, the carry becomes the last bit moved out of the operand, and a strobe tells the flag register to load it. Distances of 32 and above have fixed outcomes for both the result and the carry. A zero distance leaves both the operand and the flag untouched. The flag register and instruction decoding stay outside the block.

Top module: `rshift_carry`

## Requirements
- R1: With a shift distance of 0, `res` equals `opnd`, `carry_out` equals `carry_in` and `carry_wr` is 0, whatever `carry_en` is.
- R2: With `arith`=1 and distance n from 1 to 31, `res[31-n:0]` equals `opnd[31:n]` and the top n bits of `res` all equal `opnd[31]`.
- R3: With `arith`=0 and distance n from 1 to 31, `res[31-n:0]` equals `opnd[31:n]` and the top n bits of `res` are 0.
- R4: With `carry_en`=1 and distance n from 1 to 32, `carry_wr` is 1 and `carry_out` equals `opnd[n-1]`, for both shift types.
- R5: With `arith`=1 and distance 32 or more, every bit of `res` equals `opnd[31]`, and with `carry_en`=1 `carry_out` equals `opnd[31]`.
- R6: With `arith`=0 and distance 32 or more, `res` is 0. With `carry_en`=1 the carry is `opnd[31]` at distance exactly 32 and 0 at any distance above 32.
- R7: With `carry_en`=0, `carry_wr` is 0 and `carry_out` equals `carry_in`, and `res` is the same as with `carry_en`=1.
- R8: All eight bits of `amt` count: distances such as 64, 128 and 255, whose low five bits are zero or small, behave as distances of 32 or more, not as their low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Value to shift |
| amt | input | 8 | Shift distance, 0 to 255 |
| arith | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| carry_in | input | 1 | Present carry flag |
| carry_en | input | 1 | Allows the carry to be updated |
| res | output | 32 | Shifted value |
| carry_out | output | 1 | Next carry flag |
| carry_wr | output | 1 | High when the flag is to be loaded with `carry_out` |

## Verification
The block holds no state, so a fault in a mux stage shows on `res` and `carry_out` in the same evaluation as the faulty input, but only for distances whose bit selects that stage. A fault in the saturation decode shows only for distances at or above 32, and a wrong upper-bit decode shows only for distances such as 64 or 128. The vector table and the random sweep against a bitwise reference model therefore cover every distance bit and both sides of the 32 boundary, and the carry is checked at 1, 31, 32, 33 and 255.

// File: rtl/rshift_carry.sv
module rshift_carry #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  opnd,
  input  logic [AW-1:0] amt,
  input  logic          arith,
  input  logic          carry_in,
  input  logic          carry_en,
  output logic [W-1:0]  res,
  output logic          carry_out,
  output logic          carry_wr
);

  localparam int SW = $clog2(W);

  logic         fill;
  logic         big;
  logic         at_w;
  logic         shift_c;
  logic [W:0]   stage [SW+1];

  assign fill     = arith & opnd[W-1];
  assign big      = |amt[AW-1:SW];
  assign at_w     = (amt == AW'(W));
  assign stage[0] = {opnd, 1'b0};

  // Each stage shifts by 2**k; bit 0 keeps the last bit moved out.
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W:D]} : stage[k];
  end

  assign res       = big ? {W{fill}} : stage[SW][W:1];
  assign shift_c   = big ? (at_w ? opnd[W-1] : fill) : stage[SW][0];
  assign carry_wr  = carry_en & (|amt);
  assign carry_out = carry_wr ? shift_c : carry_in;

  always_comb begin
    if (amt == '0)
      assert_zero_pass_R1: assert (res == opnd && carry_out == carry_in && !carry_wr)
        else $error("zero distance altered state");
    if (!arith && amt < AW'(W))
      assert_lsr_fill_R3: assert (res == (opnd >> amt))
        else $error("logical result mismatch");
    if (arith && amt < AW'(W))
      assert_asr_fill_R2: assert ($signed(res) == ($signed(opnd) >>> amt))
        else $error("arithmetic result mismatch");
    if (carry_en && amt != '0 && amt <= AW'(W))
      assert_last_out_R4: assert (carry_wr && carry_out == opnd[SW'(amt - AW'(1))])
        else $error("carry is not last bit out");
    if (amt >= AW'(W))
      assert_saturate_R5: assert (res == {W{arith & opnd[W-1]}})
        else $error("saturated result wrong");
    if (!carry_en)
      assert_hold_carry_R7: assert (!carry_wr && carry_out == carry_in)
        else $error("carry changed while disabled");
  end

endmodule

// File: tb/rshift_carry_tb.sv
module rshift_carry_tb;

  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [7:0]  amt;
  logic        arith, carry_in, carry_en;
  logic [31:0] res;
  logic        carry_out, carry_wr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rshift_carry u_dut (
    .opnd(opnd), .amt(amt), .arith(arith), .carry_in(carry_in),
    .carry_en(carry_en), .res(res), .carry_out(carry_out), .carry_wr(carry_wr)
  );

  // {opnd, amt, arith, cin, cen, exp_res, exp_cout, exp_wr}
  localparam logic [76:0] VEC [12] = '{
    {32'h8000_0001, 8'd0,   1'b1, 1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b0},
    {32'h8000_0000, 8'd4,   1'b1, 1'b0, 1'b1, 32'hF800_0000, 1'b0, 1'b1},
    {32'hF000_000F, 8'd4,   1'b0, 1'b0, 1'b1, 32'h0F00_0000, 1'b1, 1'b1},
    {32'h1234_5678, 8'd1,   1'b0, 1'b1, 1'b1, 32'h091A_2B3C, 1'b0, 1'b1},
    {32'h8000_0000, 8'd32,  1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b1},
    {32'h8000_0000, 8'd33,  1'b0, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1},
    {32'h8000_0000, 8'd255, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {32'h7FFF_FFFF, 8'd64,  1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 8'd31,  1'b0, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b1},
    {32'hA5A5_A5A5, 8'd8,   1'b1, 1'b1, 1'b0, 32'hFFA5_A5A5, 1'b1, 1'b0},
    {32'h0000_0001, 8'd128, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0},
    {32'hC000_0000, 8'd31,  1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1}
  };

  task automatic drive(input logic [31:0] o, input logic [7:0] a,
                       input logic ar, input logic ci, input logic ce);
    @(negedge clk);
    opnd = o; amt = a; arith = ar; carry_in = ci; carry_en = ce;
    @(posedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] er,
                       input logic ec, input logic ew);
    checks++;
    if (res !== er || carry_out !== ec || carry_wr !== ew) begin
      errors++;
      $display("FAIL %s: opnd=%h amt=%0d arith=%b got res=%h c=%b wr=%b exp res=%h c=%b wr=%b",
               req, opnd, amt, arith, res, carry_out, carry_wr, er, ec, ew);
    end
  endtask

  function automatic logic [33:0] model(input logic [31:0] o, input int n,
                                        input logic ar, input logic ci, input logic ce);
    logic [31:0] r;
    logic        f, c;
    f = ar & o[31];
    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? o[i + n] : f;
    if (!ce || n == 0) c = ci;
    else if (n <= 32)  c = o[n - 1];
    else               c = f;
    return {r, c, ce && n != 0};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [33:0] m;
    // Idle state with all inputs low (R1: zero distance passes through)
    drive(32'h0, 8'd0, 1'b0, 1'b0, 1'b0);
    check("R1 idle", 32'h0, 1'b0, 1'b0);
    drive(32'hDEAD_BEEF, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R1 zero distance enabled", 32'hDEAD_BEEF, 1'b0, 1'b0);

    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][76:45], VEC[i][44:37], VEC[i][36], VEC[i][35], VEC[i][34]);
      check("R2/R3/R4/R5/R6/R7/R8 table", VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R4: carry at every distance 1..32 for a walking single bit
    for (int n = 1; n <= 32; n++) begin
      drive(32'h1 << (n - 1), 8'(n), 1'b0, 1'b0, 1'b1);
      m = model(32'h1 << (n - 1), n, 1'b0, 1'b0, 1'b1);
      check("R4 walking bit", m[33:2], m[1], m[0]);
    end

    // R7: same operand with enable off keeps result, holds carry
    drive(32'h8000_00F0, 8'd5, 1'b1, 1'b0, 1'b0);
    check("R7 enable off", 32'hFC00_0007, 1'b0, 1'b0);

    // R8: every distance 0..255 with a signed operand, both types
    for (int n = 0; n < 256; n++) begin
      for (int t = 0; t < 2; t++) begin
        drive(32'h9234_5671, 8'(n), t[0], 1'b1, 1'b1);
        m = model(32'h9234_5671, n, t[0], 1'b1, 1'b1);
        check("R8 distance sweep", m[33:2], m[1], m[0]);
      end
    end

    // R2 R3 R5 R6: random sweep against the model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] o;
      logic [7:0]  a;
      logic        ar, ci, ce;
      o = $urandom; a = 8'($urandom); ar = 1'($urandom);
      ci = 1'($urandom); ce = 1'($urandom);
      if (k % 3 == 0) a = 8'(a % 40);
      drive(o, a, ar, ci, ce);
      m = model(o, int'(a), ar, ci, ce);
      check("R2/R3/R5/R6 random", m[33:2], m[1], m[0]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule